// File: doc/BRIEF.md
# Skew-Tolerant Sample Capture Buffer

This block carries a stream of data samples from an input clock that reaches the fabric over ordinary routing, without a dedicated low-skew clock tree, into a common system clock that runs a little faster. Because the skew on such a clock is large, no register on the input side captures a value on the same edge that launched it. Every path on that side goes from a rising edge to a falling edge, or from a falling edge to a rising edge, which gives each path half a period of hold margin.

On the input side, the write enable and the sample are registered on the falling edge. The write pointer is a pair of registers. The rising-edge register takes the falling-edge register's value, plus one when a sample is accepted. The falling-edge register then copies the rising-edge register. A small memory with combinational read is written on the rising edge, at the address held in the falling-edge register. A gray-coded copy of the pointer is registered on the falling edge.

The system side passes that gray pointer through two flops and converts it back to binary. It then drains one entry per cycle while its read pointer trails the write pointer, and marks each entry with a one-cycle valid strobe. A single asynchronous, active-high clear empties both domains.

Top module: `skew_tolerant_capture`

## Requirements
- R1: While `clr` is high, and from its assertion onward, both write-pointer registers, the gray pointer, the synchronizer stages and the read pointer are zero, `rd_valid` is low and `rd_data` is zero.
- R2: A sample is accepted when `wr_en` is high at a falling edge of `in_clk`. Each accepted sample advances the write pointer by exactly one. A falling edge with `wr_en` low leaves the pointer unchanged.
- R3: On every rising edge of `in_clk`, the rising-edge pointer register loads the falling-edge register's value, plus one when a sample was accepted. It never loads its own value plus one. On every falling edge, the falling-edge register copies the rising-edge register. At each falling edge, the rising-edge register therefore equals the falling-edge register or exceeds it by one.
- R4: The gray-coded write pointer changes in at most one bit per falling edge of `in_clk`.
- R5: The synchronized gray pointer changes in at most one bit per `sys_clk` cycle.
- R6: `rd_valid` is high for one `sys_clk` cycle per entry. The read pointer advances by one in exactly the cycles in which `rd_valid` is high.
- R7: The samples appear on `rd_data` in the order they were accepted, each exactly once.
- R8: While no samples are accepted and every accepted sample has been delivered, `rd_valid` stays low.
- R9: The read pointer never moves ahead of the synchronized write pointer, and the gap between the two never exceeds the memory depth of 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Locally routed input clock |
| sys_clk | input | 1 | Common system clock, slightly faster than `in_clk` |
| clr | input | 1 | Asynchronous active-high clear for both domains |
| wr_en | input | 1 | Sample valid, registered on the falling edge of `in_clk` |
| wr_data | input | DATA_W | Sample value, registered on the falling edge of `in_clk` |
| rd_data | output | DATA_W | Drained sample, registered on `sys_clk` |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` as a new sample |

## Verification
The assertions check the per-edge invariants on every cycle:
- the two pointer registers never drift more than one count apart;
- the gray pointer and its synchronized copy change at most one bit per step;
- the read pointer moves only together with the valid strobe;
- the read pointer never passes the write pointer and never trails it by more than the depth.

Only the bench's scenarios show that the content crosses correctly, that is, that each accepted sample emerges once and in order across an arbitrary phase between the clocks. They also show that idle gaps and a mid-run clear produce no spurious strobe. The bench covers these with back-to-back writes, sparse random writes, an idle stretch and a restart after clear.

// File: rtl/skew_capture_pkg.sv
package skew_capture_pkg;

  localparam int unsigned CONV_W = 32;

  function automatic logic [CONV_W-1:0] to_gray(input logic [CONV_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CONV_W-1:0] from_gray(input logic [CONV_W-1:0] g);
    logic [CONV_W-1:0] b;
    b[CONV_W-1] = g[CONV_W-1];
    for (int i = CONV_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/alt_edge_wptr.sv
module alt_edge_wptr #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              in_clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              stage_en,
  output logic [DATA_W-1:0] stage_data,
  output logic [ADDR_W-1:0] stage_addr,
  output logic [PTR_W-1:0]  wr_gray
);
  import skew_capture_pkg::*;

  logic [PTR_W-1:0]  rise_cnt;
  logic [PTR_W-1:0]  fall_cnt;
  logic [CONV_W-1:0] gray_full;

  always_comb gray_full = to_gray(CONV_W'(rise_cnt));

  // falling edge: capture inputs, copy the rising-edge count, publish gray
  always_ff @(negedge in_clk or posedge clr) begin
    if (clr) begin
      stage_en   <= 1'b0;
      stage_data <= '0;
      fall_cnt   <= '0;
      wr_gray    <= '0;
    end else begin
      stage_en   <= wr_en;
      stage_data <= wr_data;
      fall_cnt   <= rise_cnt;
      wr_gray    <= gray_full[PTR_W-1:0];
    end
  end

  // rising edge: feedback comes from the opposite-edge register only
  always_ff @(posedge in_clk or posedge clr) begin
    if (clr) begin
      rise_cnt <= '0;
    end else if (stage_en) begin
      rise_cnt <= fall_cnt + 1'b1;
    end else begin
      rise_cnt <= fall_cnt;
    end
  end

  assign stage_addr = fall_cnt[ADDR_W-1:0];

  a_r3_pair_lockstep: assert property (@(negedge in_clk) disable iff (clr)
    (rise_cnt == fall_cnt) || (rise_cnt == PTR_W'(fall_cnt + 1'b1)));

  a_r3_fall_copies_rise: assert property (@(negedge in_clk) disable iff (clr)
    1'b1 |=> (fall_cnt == $past(rise_cnt)));

  a_r2_step_on_accept: assert property (@(negedge in_clk) disable iff (clr)
    !$past(stage_en) |=> (fall_cnt == $past(fall_cnt)) || (fall_cnt == PTR_W'($past(fall_cnt) + 1'b1)));

  a_r4_gray_one_bit: assert property (@(negedge in_clk) disable iff (clr)
    1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));

endmodule

// File: rtl/capture_ram.sv
module capture_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // written on the rising edge; address and data were launched on the falling edge
  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/gray_sync2.sv
module gray_sync2 #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  a_r5_sync_one_bit: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> ($countones(q ^ $past(q)) <= 1));

endmodule

// File: rtl/drain_ctrl.sv
module drain_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PTR_W = ADDR_W + 1,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              sys_clk,
  input  logic              clr,
  input  logic [PTR_W-1:0]  wgray_sync,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import skew_capture_pkg::*;

  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_bin;
  logic [CONV_W-1:0] bin_full;
  logic              pending;

  always_comb begin
    bin_full = from_gray(CONV_W'(wgray_sync));
    wr_bin   = bin_full[PTR_W-1:0];
    pending  = (wr_bin != rd_ptr);
  end

  assign mem_addr = rd_ptr[ADDR_W-1:0];

  always_ff @(posedge sys_clk or posedge clr) begin
    if (clr) begin
      rd_ptr   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pending;
      if (pending) begin
        rd_data <= mem_data;
        rd_ptr  <= rd_ptr + 1'b1;
      end
    end
  end

  a_r6_ptr_moves_with_valid: assert property (@(posedge sys_clk) disable iff (clr)
    1'b1 |=> ((rd_ptr != $past(rd_ptr)) == rd_valid));

  a_r6_ptr_step_one: assert property (@(posedge sys_clk) disable iff (clr)
    rd_valid |-> (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)));

  a_r9_no_overrun: assert property (@(posedge sys_clk) disable iff (clr)
    PTR_W'(wr_bin - rd_ptr) <= PTR_W'(DEPTH));

  a_r1_clear_idle: assert property (@(posedge sys_clk)
    clr |-> (!rd_valid && rd_ptr == '0));

endmodule

// File: rtl/skew_tolerant_capture.sv
module skew_tolerant_capture #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              in_clk,
  input  logic              sys_clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              st_en;
  logic [DATA_W-1:0] st_data;
  logic [ADDR_W-1:0] st_addr;
  logic [PTR_W-1:0]  gray_in;
  logic [PTR_W-1:0]  gray_sys;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] mem_q;

  alt_edge_wptr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wptr (
    .in_clk     (in_clk),
    .clr        (clr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .stage_en   (st_en),
    .stage_data (st_data),
    .stage_addr (st_addr),
    .wr_gray    (gray_in)
  );

  capture_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk  (in_clk),
    .wr_en   (st_en),
    .wr_addr (st_addr),
    .wr_data (st_data),
    .rd_addr (rd_addr),
    .rd_data (mem_q)
  );

  gray_sync2 #(.WIDTH(PTR_W)) u_sync (
    .clk (sys_clk),
    .clr (clr),
    .d   (gray_in),
    .q   (gray_sys)
  );

  drain_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_drain (
    .sys_clk    (sys_clk),
    .clr        (clr),
    .wgray_sync (gray_sys),
    .mem_data   (mem_q),
    .mem_addr   (rd_addr),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

endmodule

// File: tb/sim_skew_tolerant_capture.sv
`timescale 1ns/100ps
module sim_skew_tolerant_capture;
  localparam real CLK_PERIOD = 10.0;
  localparam real IN_PERIOD  = 11.0;
  localparam int  DW = 8;

  logic          in_clk = 1'b0;
  logic          sys_clk = 1'b0;
  logic          clr = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int tests = 0;
  int fails = 0;
  int pushed = 0;
  int popped = 0;
  int idle_valids = 0;
  bit idle_window = 1'b0;
  bit done = 1'b0;
  logic [DW-1:0] expq [$];

  skew_tolerant_capture #(.DATA_W(DW), .ADDR_W(3)) u0 (
    .in_clk(in_clk), .sys_clk(sys_clk), .clr(clr),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2.0) sys_clk = ~sys_clk;

  initial begin
    #($urandom_range(0, 100) / 10.0);
    forever #(IN_PERIOD/2.0) in_clk = ~in_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: changes inputs on the rising edge, the design samples them on the falling edge
  task automatic put(input bit en, input logic [DW-1:0] d);
    @(posedge in_clk);
    wr_en   <= en;
    wr_data <= d;
    if (en) begin
      expq.push_back(d);
      pushed++;
    end
  endtask

  // monitor: scoreboard pop on each strobe
  always @(negedge sys_clk) begin
    if (!clr && rd_valid) begin
      if (idle_window) idle_valids++;
      if (expq.size() == 0) begin
        check(1'b0, "R8 strobe with nothing pending", 1, 0);
      end else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        popped++;
        check(rd_data == e, "R7 order/data", int'(rd_data), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge sys_clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: clear state
    repeat (4) @(negedge sys_clk);
    check(rd_valid == 1'b0, "R1 valid low in clear", int'(rd_valid), 0);
    check(rd_data == '0, "R1 data zero in clear", int'(rd_data), 0);
    @(negedge in_clk);
    #1 clr = 1'b0;

    // back-to-back writes (R2, R3)
    for (int i = 0; i < 40; i++) put(1'b1, DW'(i * 7 + 3));
    put(1'b0, '0);
    // sparse random writes (R2, R4, R5)
    for (int i = 0; i < 80; i++) put(1'($urandom_range(0, 1)), DW'($urandom));
    put(1'b0, '0);
    repeat (30) @(negedge sys_clk);
    check(expq.size() == 0, "R2 R7 all samples delivered", expq.size(), 0);
    check(popped == pushed, "R3 R4 R5 output count", popped, pushed);

    // R8: idle stretch, nothing may appear
    idle_window = 1'b1;
    for (int i = 0; i < 50; i++) put(1'b0, DW'(i));
    idle_window = 1'b0;
    check(idle_valids == 0, "R8 no strobe while idle", idle_valids, 0);

    // R1: clear mid-run, then restart
    @(negedge sys_clk);
    clr = 1'b1;
    #1;
    check(rd_valid == 1'b0, "R1 valid drops on clear", int'(rd_valid), 0);
    check(rd_data == '0, "R1 data cleared", int'(rd_data), 0);
    repeat (3) @(negedge sys_clk);
    check(rd_valid == 1'b0, "R1 valid held low", int'(rd_valid), 0);
    @(negedge in_clk);
    #1 clr = 1'b0;
    repeat (4) @(negedge sys_clk);
    check(rd_valid == 1'b0, "R8 R9 no stale read after clear", int'(rd_valid), 0);

    // restart with bursts separated by gaps (R6, R9)
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 12; i++) put(1'b1, DW'(8'hA0 + b * 12 + i));
      for (int i = 0; i < 3; i++) put(1'b0, '0);
    end
    repeat (30) @(negedge sys_clk);
    check(expq.size() == 0, "R6 R9 restart stream drained", expq.size(), 0);
    check(popped == pushed, "R6 one strobe per sample", popped, pushed);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule